// File: doc/BRIEF.md
# Core-Local Timer and Software Interrupt Unit

This block gives a single hart its machine-level timer and software interrupts. Software reaches it through a small byte-wide bus: a 16-bit offset inside the block's window, separate read and write strobes, eight bits of write data and eight bits of read data. Behind that bus sit three pieces of state. The first is a one-bit software-interrupt flag. The second is a 64-bit compare value. The third is a 64-bit time counter. The compare value and the time counter are each kept as two 32-bit halves.

The time counter advances by one on every cycle in which the tick enable is high. The timer interrupt is asserted while the time is at or past the compare value, and only if neither compare half is zero. The software interrupt output mirrors the stored flag. Software may write every byte of the compare value and of the counter on its own. A counter write made in the same cycle as a tick wins over the increment.

Top module: `core_irq_timer`

## Requirements
- R1: After reset, sw_irq and tmr_irq are 0, bus_rdata is 0, and every byte of the compare value and of the time counter reads as 0.
- R2: At offset 0x0000, bit 0 of a written byte is stored and drives sw_irq from the cycle after the write. Offset 0x0000 reads back {7'b0, flag}. Offsets 0x0001 to 0x0003 read as 0, and writes to them have no effect.
- R3: The compare value sits at offsets 0x4000 to 0x4007 in little-endian order: 0x4000 is bits 7:0 and 0x4007 is bits 63:56. A write changes only the addressed byte.
- R4: The time counter sits at offsets 0xBFF8 to 0xBFFF in little-endian order: 0xBFF8 is bits 7:0. A write changes only the addressed byte.
- R5: Each cycle with tick_en high adds one to the low 32-bit half. The high half gains one when the low half wraps from 0xFFFFFFFF to 0. With tick_en low, the counter holds.
- R6: tmr_irq is 1 exactly when time >= compare (both 64-bit, unsigned) and both compare halves are nonzero. It reflects the state that each clock edge leaves.
- R7: A write to any time byte in a cycle with tick_en high cancels that cycle's increment, so the counter holds exactly the written value.
- R8: Reads of offsets outside the three register windows return 0, and writes there change no state.
- R9: bus_rdata presents the addressed byte in the cycle after a cycle with bus_rd high, and keeps its value while bus_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Timebase tick; the counter advances once per high cycle |
| bus_addr | input | 16 | Byte offset within the block window |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Registered read data byte |
| sw_irq | output | 1 | Machine software interrupt |
| tmr_irq | output | 1 | Machine timer interrupt |

## Verification
A write takes effect at the first rising edge after it is presented. From that edge on, sw_irq and tmr_irq show the new state with no extra delay. Read data arrives one edge after the read strobe. The bench drives inputs on falling edges. For each read it queues the expected byte, and a monitor checks that byte at the falling edge that follows the capturing rising edge. The interrupt outputs are checked at the falling edge after the write or tick edge that changed them. Tick bursts are counted in rising edges, so the expected counter values, including the carry out of the low half, follow directly.

// File: rtl/ctimer_pkg.sv
package ctimer_pkg;

  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_SWI  = 2'd1,
    TGT_CMP  = 2'd2,
    TGT_TIME = 2'd3
  } tgt_e;

endpackage

// File: rtl/ctimer_decode.sv
module ctimer_decode
  import ctimer_pkg::*;
#(
  parameter int unsigned         ADDR_W     = 16,
  parameter int unsigned         LANE_IDX_W = 2,
  parameter logic [ADDR_W-1:0]   SWI_OFS    = 'h0000,
  parameter logic [ADDR_W-1:0]   CMP_OFS    = 'h4000,
  parameter logic [ADDR_W-1:0]   TIME_OFS   = 'hBFF8
) (
  input  logic [ADDR_W-1:0]     addr,
  output tgt_e                  tgt,
  output logic                  hi,
  output logic [LANE_IDX_W-1:0] lane
);

  localparam int unsigned REG_BITS = LANE_IDX_W + 1;

  always_comb begin
    tgt = TGT_NONE;
    if (addr[ADDR_W-1:REG_BITS] == CMP_OFS[ADDR_W-1:REG_BITS]) begin
      tgt = TGT_CMP;
    end else if (addr[ADDR_W-1:REG_BITS] == TIME_OFS[ADDR_W-1:REG_BITS]) begin
      tgt = TGT_TIME;
    end else if (addr[ADDR_W-1:LANE_IDX_W] == SWI_OFS[ADDR_W-1:LANE_IDX_W]) begin
      tgt = TGT_SWI;
    end
  end

  assign hi   = addr[LANE_IDX_W];
  assign lane = addr[LANE_IDX_W-1:0];

endmodule

// File: rtl/ctimer_half.sv
module ctimer_half
  import ctimer_pkg::*;
#(
  parameter int unsigned HALF_W     = 32,
  parameter int unsigned LANE_IDX_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [LANE_IDX_W-1:0] lane,
  input  logic [BYTE_W-1:0]     wdata,
  input  logic                  inc_en,
  output logic [HALF_W-1:0]     q,
  output logic                  all_ones
);

  localparam int unsigned LANES = HALF_W / BYTE_W;

  logic [HALF_W-1:0] merged;
  logic [HALF_W-1:0] q_nxt;
  logic              upd_en;

  // byte-lane merge: only the addressed lane takes the new data
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign merged[g*BYTE_W +: BYTE_W] =
      (lane == LANE_IDX_W'(g)) ? wdata : q[g*BYTE_W +: BYTE_W];
  end

  always_comb begin
    if (wr_en) begin
      q_nxt = merged;
    end else if (inc_en) begin
      q_nxt = q + HALF_W'(1);
    end else begin
      q_nxt = q;
    end
  end

  assign upd_en   = wr_en | inc_en;
  assign all_ones = &q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (upd_en) begin
      q <= q_nxt;
    end
  end

endmodule

// File: rtl/ctimer_rdmux.sv
module ctimer_rdmux
  import ctimer_pkg::*;
#(
  parameter int unsigned HALF_W     = 32,
  parameter int unsigned LANE_IDX_W = 2
) (
  input  tgt_e                  tgt,
  input  logic                  hi,
  input  logic [LANE_IDX_W-1:0] lane,
  input  logic                  swi,
  input  logic [HALF_W-1:0]     cmp_lo,
  input  logic [HALF_W-1:0]     cmp_hi,
  input  logic [HALF_W-1:0]     time_lo,
  input  logic [HALF_W-1:0]     time_hi,
  output logic [BYTE_W-1:0]     rd_byte
);

  logic [HALF_W-1:0] cmp_sel;
  logic [HALF_W-1:0] time_sel;

  assign cmp_sel  = hi ? cmp_hi  : cmp_lo;
  assign time_sel = hi ? time_hi : time_lo;

  always_comb begin
    rd_byte = '0;
    unique case (tgt)
      TGT_SWI:  rd_byte = (!hi && lane == '0) ? {{(BYTE_W-1){1'b0}}, swi} : '0;
      TGT_CMP:  rd_byte = cmp_sel[{lane, 3'b000} +: BYTE_W];
      TGT_TIME: rd_byte = time_sel[{lane, 3'b000} +: BYTE_W];
      default:  rd_byte = '0;
    endcase
  end

endmodule

// File: rtl/core_irq_timer.sv
module core_irq_timer
  import ctimer_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 16,
  parameter int unsigned       HALF_W   = 32,
  parameter logic [ADDR_W-1:0] SWI_OFS  = 'h0000,
  parameter logic [ADDR_W-1:0] CMP_OFS  = 'h4000,
  parameter logic [ADDR_W-1:0] TIME_OFS = 'hBFF8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              sw_irq,
  output logic              tmr_irq
);

  localparam int unsigned LANES      = HALF_W / BYTE_W;
  localparam int unsigned LANE_IDX_W = $clog2(LANES);
  localparam int unsigned FULL_W     = 2 * HALF_W;

  tgt_e                  tgt;
  logic                  sel_hi;
  logic [LANE_IDX_W-1:0] sel_lane;

  ctimer_decode #(
    .ADDR_W(ADDR_W), .LANE_IDX_W(LANE_IDX_W),
    .SWI_OFS(SWI_OFS), .CMP_OFS(CMP_OFS), .TIME_OFS(TIME_OFS)
  ) u_decode (
    .addr(bus_addr), .tgt(tgt), .hi(sel_hi), .lane(sel_lane)
  );

  // ---------------- software interrupt flag ----------------
  logic swi_q, swi_nxt, swi_en;

  assign swi_en  = bus_wr && (tgt == TGT_SWI) && !sel_hi && (sel_lane == '0);
  assign swi_nxt = bus_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      swi_q <= 1'b0;
    end else if (swi_en) begin
      swi_q <= swi_nxt;
    end
  end

  // ---------------- compare halves ----------------
  logic [HALF_W-1:0] cmp_half [2];
  logic [1:0]        cmp_ones;

  for (genvar h = 0; h < 2; h++) begin : g_cmp
    logic cmp_wr;
    assign cmp_wr = bus_wr && (tgt == TGT_CMP) && (sel_hi == h[0]);
    ctimer_half #(.HALF_W(HALF_W), .LANE_IDX_W(LANE_IDX_W)) u_half (
      .clk(clk), .rst_n(rst_n), .wr_en(cmp_wr), .lane(sel_lane),
      .wdata(bus_wdata), .inc_en(1'b0), .q(cmp_half[h]), .all_ones(cmp_ones[h])
    );
  end

  // ---------------- time counter ----------------
  logic              time_wr_any;
  logic              tick_go;
  logic              time_lo_wr, time_hi_wr;
  logic              lo_ones, hi_ones;
  logic              hi_inc;
  logic [HALF_W-1:0] time_lo, time_hi;

  assign time_wr_any = bus_wr && (tgt == TGT_TIME);
  assign tick_go     = tick_en && !time_wr_any;     // write wins over tick
  assign time_lo_wr  = time_wr_any && !sel_hi;
  assign time_hi_wr  = time_wr_any &&  sel_hi;
  assign hi_inc      = tick_go && lo_ones;          // carry on low wrap

  ctimer_half #(.HALF_W(HALF_W), .LANE_IDX_W(LANE_IDX_W)) u_time_lo (
    .clk(clk), .rst_n(rst_n), .wr_en(time_lo_wr), .lane(sel_lane),
    .wdata(bus_wdata), .inc_en(tick_go), .q(time_lo), .all_ones(lo_ones)
  );

  ctimer_half #(.HALF_W(HALF_W), .LANE_IDX_W(LANE_IDX_W)) u_time_hi (
    .clk(clk), .rst_n(rst_n), .wr_en(time_hi_wr), .lane(sel_lane),
    .wdata(bus_wdata), .inc_en(hi_inc), .q(time_hi), .all_ones(hi_ones)
  );

  logic [FULL_W-1:0] time_full;
  logic [FULL_W-1:0] cmp_full;
  logic              cmp_armed;
  logic              time_reached;

  assign time_full    = {time_hi, time_lo};
  assign cmp_full     = {cmp_half[1], cmp_half[0]};
  assign cmp_armed    = (cmp_half[0] != '0) && (cmp_half[1] != '0);
  assign time_reached = (time_full >= cmp_full);

  // ---------------- read path ----------------
  logic [BYTE_W-1:0] rd_byte;
  logic [BYTE_W-1:0] rdata_q;

  ctimer_rdmux #(.HALF_W(HALF_W), .LANE_IDX_W(LANE_IDX_W)) u_rdmux (
    .tgt(tgt), .hi(sel_hi), .lane(sel_lane), .swi(swi_q),
    .cmp_lo(cmp_half[0]), .cmp_hi(cmp_half[1]),
    .time_lo(time_lo), .time_hi(time_hi), .rd_byte(rd_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (bus_rd) begin
      rdata_q <= rd_byte;
    end
  end

  assign bus_rdata = rdata_q;
  assign sw_irq    = swi_q;
  assign tmr_irq   = cmp_armed && time_reached;

  // all-ones flags of the compare halves and the high time half are unused
  logic unused_ok;
  assign unused_ok = ^{cmp_ones, hi_ones};

endmodule

// File: rtl/ctimer_chk.sv
module ctimer_chk #(
  parameter int unsigned       ADDR_W   = 16,
  parameter int unsigned       HALF_W   = 32,
  parameter logic [ADDR_W-1:0] SWI_OFS  = 'h0000,
  parameter logic [ADDR_W-1:0] CMP_OFS  = 'h4000,
  parameter logic [ADDR_W-1:0] TIME_OFS = 'hBFF8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        bus_rdata,
  input logic              sw_irq,
  input logic              tmr_irq,
  input logic [2*HALF_W-1:0] time_q,
  input logic [2*HALF_W-1:0] cmp_q
);

  localparam int unsigned LIDX = $clog2(HALF_W / 8);
  localparam int unsigned RB   = LIDX + 1;

  logic time_hit, cmp_hit, swi_hit, swi_b0;
  assign time_hit = bus_addr[ADDR_W-1:RB] == TIME_OFS[ADDR_W-1:RB];
  assign cmp_hit  = bus_addr[ADDR_W-1:RB] == CMP_OFS[ADDR_W-1:RB];
  assign swi_hit  = bus_addr[ADDR_W-1:LIDX] == SWI_OFS[ADDR_W-1:LIDX];
  assign swi_b0   = bus_addr == SWI_OFS;

  logic          twr_d;
  logic [RB-1:0] twr_ofs;
  logic [7:0]    twr_dat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      twr_d   <= 1'b0;
      twr_ofs <= '0;
      twr_dat <= '0;
    end else begin
      twr_d   <= bus_wr && time_hit;
      twr_ofs <= bus_addr[RB-1:0];
      twr_dat <= bus_wdata;
    end
  end

  AST_TIME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en && !(bus_wr && time_hit) |=> time_q == $past(time_q) + 1'b1); // R5

  AST_TIME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en && !(bus_wr && time_hit) |=> $stable(time_q)); // R5

  AST_TIME_WR_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    twr_d |-> time_q[{twr_ofs, 3'b000} +: 8] == twr_dat); // R7

  AST_SWI_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && swi_b0 |=> sw_irq == $past(bus_wdata[0])); // R2

  AST_SWI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && swi_b0) |=> $stable(sw_irq)); // R2

  AST_CMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && cmp_hit) |=> $stable(cmp_q)); // R3

  AST_TMR_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_q[HALF_W-1:0] == '0 || cmp_q[2*HALF_W-1:HALF_W] == '0) |-> !tmr_irq); // R6

  AST_RD_UNMAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && !(swi_hit || cmp_hit || time_hit) |=> bus_rdata == 8'h00); // R8

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata)); // R9

endmodule

bind core_irq_timer ctimer_chk #(
  .ADDR_W(ADDR_W), .HALF_W(HALF_W),
  .SWI_OFS(SWI_OFS), .CMP_OFS(CMP_OFS), .TIME_OFS(TIME_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
  .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .sw_irq(sw_irq), .tmr_irq(tmr_irq),
  .time_q(time_full), .cmp_q(cmp_full)
);

// File: tb/test_core_irq_timer.sv
module test_core_irq_timer;

  localparam logic [15:0] A_SWI  = 16'h0000;
  localparam logic [15:0] A_CMP  = 16'h4000;
  localparam logic [15:0] A_TIME = 16'hBFF8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        sw_irq, tmr_irq;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;   // 200 MHz

  core_irq_timer i_core_irq_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .sw_irq(sw_irq), .tmr_irq(tmr_irq)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_byte(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_byte(input logic [15:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wr64(input logic [15:0] base, input logic [63:0] v);
    for (int i = 0; i < 8; i++) wr_byte(base + 16'(i), v[i*8 +: 8]);
  endtask

  task automatic rd64(input logic [15:0] base, input logic [63:0] v, input string tag);
    for (int i = 0; i < 8; i++) rd_byte(base + 16'(i), v[i*8 +: 8], tag);
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  // scoreboard monitor: read data due at the falling edge after capture
  initial begin
    forever begin
      @(posedge clk);
      if (bus_rd === 1'b1) begin
        @(negedge clk);
        if (exp_q.size() == 0) begin
          chk("scoreboard underflow", 1, 0);
        end else begin
          chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk("watchdog expired", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 sw_irq", sw_irq, 0);
    chk("R1 tmr_irq", tmr_irq, 0);
    chk("R1 rdata", bus_rdata, 0);
    rd64(A_CMP, 64'h0, "R1 cmp reset");
    rd64(A_TIME, 64'h0, "R1 time reset");
    rd_byte(A_SWI, 8'h00, "R1 swi reset");

    // R2 software interrupt flag
    wr_byte(A_SWI, 8'hFF);
    chk("R2 sw_irq set", sw_irq, 1);
    rd_byte(A_SWI, 8'h01, "R2 swi readback");
    wr_byte(A_SWI + 16'd1, 8'hFF);
    rd_byte(A_SWI + 16'd1, 8'h00, "R2 swi byte1 zero");
    rd_byte(A_SWI + 16'd3, 8'h00, "R2 swi byte3 zero");
    chk("R2 sw_irq unchanged by byte1", sw_irq, 1);
    wr_byte(A_SWI, 8'hFE);
    chk("R2 sw_irq clear", sw_irq, 0);

    // R3 compare byte lanes
    wr64(A_CMP, 64'h8877665544332211);
    rd64(A_CMP, 64'h8877665544332211, "R3 cmp readback");
    wr_byte(A_CMP + 16'd2, 8'hAA);
    rd64(A_CMP, 64'h88776655_44AA2211, "R3 cmp single lane");

    // R4 time byte lanes
    wr64(A_TIME, 64'h0102030405060708);
    chk("R6 tmr_irq below cmp", tmr_irq, 0);
    rd64(A_TIME, 64'h0102030405060708, "R4 time readback");
    wr_byte(A_TIME + 16'd5, 8'hEE);
    rd64(A_TIME, 64'h0102EE0405060708, "R4 time single lane");

    // R6 compare threshold and masking
    wr64(A_CMP, 64'h00000002_00000010);
    wr64(A_TIME, 64'h00000002_0000000F);
    chk("R6 tmr_irq one below", tmr_irq, 0);
    ticks(1);
    chk("R6 tmr_irq at equal", tmr_irq, 1);
    ticks(5);
    chk("R6 tmr_irq above", tmr_irq, 1);
    wr_byte(A_CMP + 16'd4, 8'h00);
    chk("R6 tmr_irq masked by zero high half", tmr_irq, 0);
    wr_byte(A_CMP + 16'd4, 8'h02);
    chk("R6 tmr_irq rearmed", tmr_irq, 1);
    wr_byte(A_CMP, 8'h00);
    chk("R6 tmr_irq masked by zero low half", tmr_irq, 0);

    // R5 carry and hold
    wr64(A_TIME, 64'h00000005_FFFFFFFF);
    ticks(1);
    rd64(A_TIME, 64'h00000006_00000000, "R5 low wrap carries");
    repeat (5) @(negedge clk);
    rd64(A_TIME, 64'h00000006_00000000, "R5 hold without tick");
    ticks(10);
    rd64(A_TIME, 64'h00000006_0000000A, "R5 ten ticks");

    // R7 write beats tick
    @(negedge clk);
    tick_en = 1'b1; bus_wr = 1'b1; bus_addr = A_TIME; bus_wdata = 8'h40;
    @(negedge clk);
    tick_en = 1'b0; bus_wr = 1'b0;
    rd64(A_TIME, 64'h00000006_00000040, "R7 write over tick");

    // R8 unmapped offsets
    wr_byte(16'h1234, 8'h5A);
    wr_byte(16'h4008, 8'h5A);
    wr_byte(16'hBFF7, 8'h5A);
    wr_byte(16'h0004, 8'h5B);
    rd_byte(16'h1234, 8'h00, "R8 unmapped read 1234");
    rd_byte(16'h4008, 8'h00, "R8 unmapped read 4008");
    rd_byte(16'hBFF7, 8'h00, "R8 unmapped read BFF7");
    rd64(A_TIME, 64'h00000006_00000040, "R8 time untouched");
    rd64(A_CMP, 64'h00000002_00000000, "R8 cmp untouched");
    rd_byte(A_SWI, 8'h00, "R8 swi untouched");
    chk("R8 sw_irq untouched", sw_irq, 0);

    // R9 read data holds while idle
    rd_byte(A_CMP + 16'd4, 8'h02, "R9 read");
    repeat (3) @(negedge clk);
    chk("R9 rdata held", bus_rdata, 8'h02);

    wait (exp_q.size() == 0);
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule